// File: doc/BRIEF.md
# Audio serial clock auto-detector

This block watches the frame sync and the bit clock of an audio serial bus from a free-running reference clock of known frequency. For every frame it measures the frame period in reference cycles and counts the bit-clock rising edges inside that frame. It then classifies the frame rate against eighteen rates in two families and the bits-per-frame ratio against thirteen allowed values.

Once two frames in a row give the same answer, the block publishes a rate code and a ratio code as status. It flags a clock error when the pair is not supported, which includes a bit-clock frequency outside the allowed window. The flag raises a one-cycle interrupt on entry and a mute request for the record path.

Two enable inputs shape the response. One gates the interrupt and the mute request. The other decides whether a clean result is copied into the active clock configuration that the downstream divider logic reads. If the frame sync stops for a programmable number of reference cycles, the bus is reported as stopped.

Top module: `audio_clk_detect`

## Requirements
- R1: After a synchronous active-low reset, the outputs are sts_rate=31, sts_ratio=15, sts_valid=0, clk_err=0, err_irq=0, mute_req=0, act_rate=31, act_ratio=15 and act_valid=0.
- R2: Rate codes follow this table order: 0..8 stand for 8, 16, 24, 32, 48, 96, 192, 384 and 768 kHz, and 9..17 stand for 7.35, 14.7, 22.05, 29.4, 44.1, 88.2, 176.4, 352.8 and 705.6 kHz. A measured period matches a rate when it lies within ±2 % of REF_HZ/rate reference cycles. A period that matches no rate gives code 31.
- R3: Ratio codes 0..12 stand for 16, 24, 32, 48, 64, 96, 128, 192, 256, 384, 512, 1024 and 2048 bit-clock rising edges per frame. Any other count gives code 15.
- R4: A pair is supported only when rate × ratio lies from 256 kHz to 24.576 MHz inclusive and both codes are known. An unsupported pair sets clk_err=1, and the status still shows its codes.
- R5: A result is taken only when two consecutive frame measurements agree on both codes. The status registers update on the 4th reference edge after the FSYNC rising edge that closes the second agreeing frame. A single odd frame leaves the status unchanged.
- R6: err_irq is a one-cycle pulse, raised only on the transition of clk_err from 0 to 1 while err_det_en=1. Further error results while clk_err is already 1 raise no pulse.
- R7: mute_req equals clk_err AND err_det_en. With err_det_en=0, neither mute_req nor err_irq is asserted, but clk_err still reports the error.
- R8: A result that is supported and taken while auto_cfg_en=1 is copied to act_rate and act_ratio and sets act_valid. With auto_cfg_en=0, or for an error result, the active configuration is held.
- R9: If no FSYNC rising edge is seen for 2^TIMEOUT_LOG2 reference cycles, the status becomes rate 31 and ratio 15 with clk_err=1. Measurement restarts from the next FSYNC edge.
- R10: A supported result clears clk_err and with it mute_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock of REF_HZ |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync_in | input | 1 | Frame sync from the audio bus (asynchronous) |
| bclk_in | input | 1 | Bit clock from the audio bus (asynchronous) |
| err_det_en | input | 1 | Enables interrupt and mute on clock error |
| auto_cfg_en | input | 1 | Enables copying results to the active configuration |
| sts_rate | output | 5 | Detected rate code |
| sts_ratio | output | 4 | Detected ratio code |
| sts_valid | output | 1 | Status holds a result |
| clk_err | output | 1 | Current result is an error or the bus has stopped |
| err_irq | output | 1 | One-cycle pulse on entry into error |
| mute_req | output | 1 | Mute request for the record channels |
| act_rate | output | 5 | Active configuration rate code |
| act_ratio | output | 4 | Active configuration ratio code |
| act_valid | output | 1 | Active configuration has been loaded |

## Verification
The status, clk_err and err_irq registers change on the 4th reference edge after the FSYNC pin edge that closes the second agreeing frame: two synchronizer flops, the measurement register, then the decision register. mute_req follows clk_err in the same cycle. A stopped bus is reported 2^TIMEOUT_LOG2 cycles after the last measured edge plus that pipeline. Each scenario drives whole frames and samples on a falling reference edge only after its last frame has been driven, which is hundreds of cycles after the last decision and before any further FSYNC edge. Interrupt pulses are counted on every falling edge, so a missing or repeated pulse shows as a count difference.

// File: rtl/acd_pkg.sv
`timescale 1ns/1ps
// Package: shared constants, code tables and the pair rule of the
// clock auto-detector. Tables are computed by case functions.
package acd_pkg;
    localparam logic [4:0] NUM_RATES  = 5'd18;
    localparam logic [3:0] NUM_RATIOS = 4'd13;
    localparam logic [4:0] RATE_UNK   = 5'd31;
    localparam logic [3:0] RATIO_UNK  = 4'd15;
    localparam logic [31:0] BCLK_MIN_HZ = 32'd256000;
    localparam logic [31:0] BCLK_MAX_HZ = 32'd24576000;

    typedef struct packed {
        logic [4:0] rate;
        logic [3:0] ratio;
    } clk_cfg_t;

    // Frame rate in Hz for a rate code; 0 for codes outside the table.
    function automatic logic [31:0] rate_hz(logic [4:0] code);
        case (code)
            5'd0:  return 32'd8000;
            5'd1:  return 32'd16000;
            5'd2:  return 32'd24000;
            5'd3:  return 32'd32000;
            5'd4:  return 32'd48000;
            5'd5:  return 32'd96000;
            5'd6:  return 32'd192000;
            5'd7:  return 32'd384000;
            5'd8:  return 32'd768000;
            5'd9:  return 32'd7350;
            5'd10: return 32'd14700;
            5'd11: return 32'd22050;
            5'd12: return 32'd29400;
            5'd13: return 32'd44100;
            5'd14: return 32'd88200;
            5'd15: return 32'd176400;
            5'd16: return 32'd352800;
            5'd17: return 32'd705600;
            default: return 32'd0;
        endcase
    endfunction

    // Bit clocks per frame for a ratio code; 0 for codes outside the table.
    function automatic logic [31:0] ratio_val(logic [3:0] code);
        case (code)
            4'd0:  return 32'd16;
            4'd1:  return 32'd24;
            4'd2:  return 32'd32;
            4'd3:  return 32'd48;
            4'd4:  return 32'd64;
            4'd5:  return 32'd96;
            4'd6:  return 32'd128;
            4'd7:  return 32'd192;
            4'd8:  return 32'd256;
            4'd9:  return 32'd384;
            4'd10: return 32'd512;
            4'd11: return 32'd1024;
            4'd12: return 32'd2048;
            default: return 32'd0;
        endcase
    endfunction

    // True when both codes are known and the bit-clock frequency is in window.
    function automatic logic pair_ok(logic [4:0] r, logic [3:0] q);
        logic [31:0] f;
        if (r >= NUM_RATES || q >= NUM_RATIOS) return 1'b0;
        f = rate_hz(r) * ratio_val(q);
        return (f >= BCLK_MIN_HZ) && (f <= BCLK_MAX_HZ);
    endfunction
endpackage

// File: rtl/acd_sync.sv
`timescale 1ns/1ps
// acd_sync: brings one asynchronous bus pin into the reference domain with
// two flops and flags its rising edge one cycle wide.
// Assumes the pin stays at each level for at least two reference cycles.
module acd_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic s1_q, s2_q, s3_q;

    // Two-flop synchronizer plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise = s2_q && !s3_q;

    a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/acd_frame_meter.sv
`timescale 1ns/1ps
// acd_frame_meter: measures each frame between two synchronized FSYNC
// rising edges in reference cycles and counts the BCLK rising edges in it.
// The first edge after reset or after a timeout only arms the meter.
// Assumes the FSYNC and BCLK rise pulses come from acd_sync.
module acd_frame_meter #(
    parameter int TIMEOUT_LOG2 = 20,
    parameter int CNT_W        = TIMEOUT_LOG2 + 1,
    parameter int BCNT_W       = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fs_rise,
    input  logic              bk_rise,
    output logic              meas_valid,
    output logic [CNT_W-1:0]  meas_period,
    output logic [BCNT_W-1:0] meas_bclks,
    output logic              timeout
);
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(1) << TIMEOUT_LOG2;
    localparam logic [BCNT_W-1:0] BMAX  = '1;

    logic [CNT_W-1:0]  cnt_q;
    logic [BCNT_W-1:0] bcnt_q;
    logic              armed_q;

    // Reference-cycle counter since the last FSYNC edge, saturating at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (fs_rise)          cnt_q <= '0;
        else if (cnt_q != LIMIT)   cnt_q <= cnt_q + CNT_W'(1);
    end

    // Bit-clock edge counter for the frame in progress, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                        bcnt_q <= '0;
        else if (fs_rise)                  bcnt_q <= '0;
        else if (bk_rise && bcnt_q != BMAX) bcnt_q <= bcnt_q + BCNT_W'(1);
    end

    // Arming: set by an FSYNC edge, cleared when the bus times out.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 armed_q <= 1'b0;
        else if (fs_rise)                           armed_q <= 1'b1;
        else if (cnt_q == LIMIT - CNT_W'(1))        armed_q <= 1'b0;
    end

    // Capture of the finished frame on each armed FSYNC edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meas_valid  <= 1'b0;
            meas_period <= '0;
            meas_bclks  <= '0;
        end else begin
            meas_valid <= fs_rise && armed_q;
            if (fs_rise && armed_q) begin
                meas_period <= cnt_q + CNT_W'(1);
                meas_bclks  <= (bcnt_q == BMAX) ? bcnt_q : bcnt_q + BCNT_W'(bk_rise);
            end
        end
    end

    // One-cycle timeout pulse when the counter reaches its limit.
    always_ff @(posedge clk) begin
        if (!rst_n) timeout <= 1'b0;
        else        timeout <= !fs_rise && (cnt_q == LIMIT - CNT_W'(1));
    end

    a_r5_meas_single: assert property (@(posedge clk) disable iff (!rst_n)
        meas_valid |=> !meas_valid);
    a_r9_timeout_once: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> !timeout);
    a_r9_no_meas_on_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !meas_valid);
endmodule

// File: rtl/acd_classifier.sv
`timescale 1ns/1ps
// acd_classifier: maps a frame measurement to rate and ratio codes.
// One tolerance window per table rate (±2 % of REF_HZ/rate) and one exact
// compare per table ratio; the lowest matching code wins.
// Assumes REF_HZ/rate fits 32 bits and CNT_W <= 32.
module acd_classifier
    import acd_pkg::*;
#(
    parameter int unsigned REF_HZ = 50_000_000,
    parameter int          CNT_W  = 21,
    parameter int          BCNT_W = 13
) (
    input  logic [CNT_W-1:0]  meas_period,
    input  logic [BCNT_W-1:0] meas_bclks,
    output clk_cfg_t          cand
);
    localparam int NR = int'(NUM_RATES);
    localparam int NQ = int'(NUM_RATIOS);

    logic [NR-1:0] rate_hit;
    logic [NQ-1:0] ratio_hit;
    logic [31:0]   per32;

    assign per32 = 32'(meas_period);

    for (genvar i = 0; i < NR; i++) begin : g_rate
        localparam logic [31:0] PER = 32'(REF_HZ) / rate_hz(5'(i));
        localparam logic [31:0] TOL = PER / 32'd50;
        assign rate_hit[i] = (per32 >= PER - TOL) && (per32 <= PER + TOL);
    end

    for (genvar q = 0; q < NQ; q++) begin : g_ratio
        localparam logic [31:0] RV = ratio_val(4'(q));
        assign ratio_hit[q] = (meas_bclks == BCNT_W'(RV));
    end

    // Priority encode both hit vectors, lowest index first.
    always_comb begin
        cand.rate  = RATE_UNK;
        cand.ratio = RATIO_UNK;
        for (int i = NR - 1; i >= 0; i--)
            if (rate_hit[i]) cand.rate = 5'(i);
        for (int q = NQ - 1; q >= 0; q--)
            if (ratio_hit[q]) cand.ratio = 4'(q);
    end
endmodule

// File: rtl/acd_decider.sv
`timescale 1ns/1ps
// acd_decider: takes a classified frame when it agrees with the previous
// one, publishes the status and the error flag, pulses the interrupt on
// entry into error, and loads the active configuration when allowed.
// Assumes meas_valid and timeout never rise in the same cycle.
module acd_decider
    import acd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     meas_valid,
    input  clk_cfg_t cand,
    input  logic     timeout,
    input  logic     err_det_en,
    input  logic     auto_cfg_en,
    output clk_cfg_t sts,
    output logic     sts_valid,
    output logic     clk_err,
    output logic     err_irq,
    output logic     mute_req,
    output clk_cfg_t act,
    output logic     act_valid
);
    localparam clk_cfg_t CFG_UNK = '{rate: RATE_UNK, ratio: RATIO_UNK};

    clk_cfg_t prev_q;
    logic     prev_ok_q;
    logic     agree, bad, err_next;

    // Agreement, pair check and the next error flag.
    always_comb begin
        agree    = meas_valid && prev_ok_q && (cand == prev_q);
        bad      = !pair_ok(cand.rate, cand.ratio);
        err_next = timeout ? 1'b1 : (agree ? bad : clk_err);
    end

    // History of the previous frame's classification.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q    <= CFG_UNK;
            prev_ok_q <= 1'b0;
        end else if (timeout) begin
            prev_ok_q <= 1'b0;
        end else if (meas_valid) begin
            prev_q    <= cand;
            prev_ok_q <= 1'b1;
        end
    end

    // Status codes and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts       <= CFG_UNK;
            sts_valid <= 1'b0;
            clk_err   <= 1'b0;
        end else begin
            clk_err <= err_next;
            if (timeout) begin
                sts       <= CFG_UNK;
                sts_valid <= 1'b1;
            end else if (agree) begin
                sts       <= cand;
                sts_valid <= 1'b1;
            end
        end
    end

    // Interrupt pulse on the 0-to-1 transition of the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) err_irq <= 1'b0;
        else        err_irq <= err_det_en && err_next && !clk_err;
    end

    // Active configuration, loaded from clean results when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act       <= CFG_UNK;
            act_valid <= 1'b0;
        end else if (agree && !bad && auto_cfg_en) begin
            act       <= cand;
            act_valid <= 1'b1;
        end
    end

    assign mute_req = clk_err && err_det_en;

    a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);
    a_r6_irq_with_err: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> clk_err);
    a_r8_act_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act) |-> $past(auto_cfg_en) && !clk_err);
    a_r9_timeout_err: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |=> clk_err && sts.rate == RATE_UNK && sts.ratio == RATIO_UNK);
    a_r5_sts_on_meas: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sts) |-> $past(meas_valid) || $past(timeout));
endmodule

// File: rtl/audio_clk_detect.sv
`timescale 1ns/1ps
// audio_clk_detect: top of the audio serial clock auto-detector.
// Synchronizes FSYNC and BCLK, measures each frame, classifies it and
// decides status, error, interrupt, mute and the active configuration.
// Assumes clk runs at REF_HZ and is fast enough to see each BCLK level
// for at least two cycles.
module audio_clk_detect
    import acd_pkg::*;
#(
    parameter int unsigned REF_HZ       = 50_000_000,
    parameter int          TIMEOUT_LOG2 = 20,
    parameter int          MAX_RATIO    = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fsync_in,
    input  logic       bclk_in,
    input  logic       err_det_en,
    input  logic       auto_cfg_en,
    output logic [4:0] sts_rate,
    output logic [3:0] sts_ratio,
    output logic       sts_valid,
    output logic       clk_err,
    output logic       err_irq,
    output logic       mute_req,
    output logic [4:0] act_rate,
    output logic [3:0] act_ratio,
    output logic       act_valid
);
    localparam int CNT_W  = TIMEOUT_LOG2 + 1;
    localparam int BCNT_W = $clog2(MAX_RATIO) + 2;

    logic              fs_rise, bk_rise;
    logic              meas_valid, timeout;
    logic [CNT_W-1:0]  meas_period;
    logic [BCNT_W-1:0] meas_bclks;
    clk_cfg_t          cand, sts, act;

    acd_sync u_fs_sync (.clk(clk), .rst_n(rst_n), .din(fsync_in), .rise(fs_rise));
    acd_sync u_bk_sync (.clk(clk), .rst_n(rst_n), .din(bclk_in),  .rise(bk_rise));

    acd_frame_meter #(
        .TIMEOUT_LOG2(TIMEOUT_LOG2), .CNT_W(CNT_W), .BCNT_W(BCNT_W)
    ) u_meter (
        .clk(clk), .rst_n(rst_n), .fs_rise(fs_rise), .bk_rise(bk_rise),
        .meas_valid(meas_valid), .meas_period(meas_period),
        .meas_bclks(meas_bclks), .timeout(timeout)
    );

    acd_classifier #(
        .REF_HZ(REF_HZ), .CNT_W(CNT_W), .BCNT_W(BCNT_W)
    ) u_class (
        .meas_period(meas_period), .meas_bclks(meas_bclks), .cand(cand)
    );

    acd_decider u_decide (
        .clk(clk), .rst_n(rst_n), .meas_valid(meas_valid), .cand(cand),
        .timeout(timeout), .err_det_en(err_det_en), .auto_cfg_en(auto_cfg_en),
        .sts(sts), .sts_valid(sts_valid), .clk_err(clk_err),
        .err_irq(err_irq), .mute_req(mute_req), .act(act), .act_valid(act_valid)
    );

    assign sts_rate  = sts.rate;
    assign sts_ratio = sts.ratio;
    assign act_rate  = act.rate;
    assign act_ratio = act.ratio;
endmodule

// File: tb/sim_audio_clk_detect.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results.
module sim_audio_clk_detect;
    localparam int TO_LOG2 = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fsync = 1'b0, bclk = 1'b0;
    logic det_en = 1'b1, cfg_en = 1'b1;
    logic [4:0] sts_rate, act_rate;
    logic [3:0] sts_ratio, act_ratio;
    logic sts_valid, clk_err, err_irq, mute_req, act_valid;

    int total = 0, bad = 0, irq_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    audio_clk_detect #(.REF_HZ(50_000_000), .TIMEOUT_LOG2(TO_LOG2)) u0 (
        .clk(clk), .rst_n(rst_n), .fsync_in(fsync), .bclk_in(bclk),
        .err_det_en(det_en), .auto_cfg_en(cfg_en),
        .sts_rate(sts_rate), .sts_ratio(sts_ratio), .sts_valid(sts_valid),
        .clk_err(clk_err), .err_irq(err_irq), .mute_req(mute_req),
        .act_rate(act_rate), .act_ratio(act_ratio), .act_valid(act_valid)
    );

    always @(negedge clk) if (rst_n && err_irq) irq_cnt++;

    task automatic chk(input string tag, input int actual, input int expected);
        total++;
        if (actual !== expected) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    // Drive n whole frames; FSYNC rises while BCLK is low.
    task automatic run_frames(input real rate, input int ratio, input int n);
        real half;
        half = 1.0e9 / (rate * ratio * 2.0);
        for (int f = 0; f < n; f++)
            for (int b = 0; b < ratio; b++) begin
                bclk = 1'b0;
                if (b == 0) fsync = 1'b1;
                if (b == ratio / 2) fsync = 1'b0;
                #(half);
                bclk = 1'b1;
                #(half);
            end
    endtask

    task automatic expect_sts(input string tag, input int r, input int q,
                              input int e, input int m);
        @(negedge clk);
        chk({tag, " rate"}, int'(sts_rate), r);
        chk({tag, " ratio"}, int'(sts_ratio), q);
        chk({tag, " err"}, int'(clk_err), e);
        chk({tag, " mute"}, int'(mute_req), m);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 sts_rate", int'(sts_rate), 31);
        chk("R1 sts_ratio", int'(sts_ratio), 15);
        chk("R1 valid", int'(sts_valid), 0);
        chk("R1 err", int'(clk_err || err_irq || mute_req), 0);
        chk("R1 act", int'({act_valid, act_rate, act_ratio}), {1'b0, 5'd31, 4'd15});
    endtask

    task automatic t_basic();
        run_frames(48000.0, 64, 4);
        expect_sts("R2 R3 48k x64", 4, 4, 0, 0);
        chk("R8 act 48k", int'({act_valid, act_rate, act_ratio}), {1'b1, 5'd4, 4'd4});
    endtask

    task automatic t_family2();
        run_frames(44100.0, 32, 4);
        expect_sts("R2 44.1k x32", 13, 2, 0, 0);
    endtask

    task automatic t_tolerance();
        run_frames(47500.0, 64, 4);
        expect_sts("R2 47.5k tol", 4, 4, 0, 0);
    endtask

    task automatic t_window_edge();
        run_frames(8000.0, 32, 4);
        expect_sts("R4 8k x32 edge", 0, 2, 0, 0);
        chk("R8 act 8k", int'({act_rate, act_ratio}), {5'd0, 4'd2});
    endtask

    task automatic t_reserved();
        int c0 = irq_cnt;
        run_frames(8000.0, 16, 4);
        expect_sts("R4 8k x16 reserved", 0, 0, 1, 1);
        chk("R6 irq once", irq_cnt - c0, 1);
        chk("R8 act held on err", int'({act_rate, act_ratio}), {5'd0, 4'd2});
    endtask

    task automatic t_odd_ratio();
        int c0 = irq_cnt;
        run_frames(48000.0, 40, 4);
        expect_sts("R3 ratio 40", 4, 15, 1, 1);
        chk("R6 no irq while in err", irq_cnt - c0, 0);
    endtask

    task automatic t_recover();
        run_frames(96000.0, 64, 4);
        expect_sts("R10 recover 96k", 5, 4, 0, 0);
        chk("R8 act 96k", int'({act_rate, act_ratio}), {5'd5, 4'd4});
    endtask

    task automatic t_agree();
        int c0;
        run_frames(48000.0, 64, 4);
        expect_sts("R5 steady", 4, 4, 0, 0);
        c0 = irq_cnt;
        run_frames(96000.0, 32, 1);
        run_frames(48000.0, 64, 1);
        expect_sts("R5 odd frame ignored", 4, 4, 0, 0);
        chk("R5 no irq", irq_cnt - c0, 0);
    endtask

    task automatic t_det_off();
        int c0 = irq_cnt;
        det_en = 1'b0;
        run_frames(8000.0, 16, 4);
        expect_sts("R7 det off", 0, 0, 1, 0);
        chk("R7 no irq", irq_cnt - c0, 0);
        det_en = 1'b1;
        @(negedge clk);
        chk("R7 mute follows enable", int'(mute_req), 1);
    endtask

    task automatic t_cfg_off();
        cfg_en = 1'b0;
        run_frames(32000.0, 48, 4);
        expect_sts("R10 32k x48", 3, 3, 0, 0);
        chk("R8 act held cfg off", int'({act_rate, act_ratio}), {5'd4, 4'd4});
        cfg_en = 1'b1;
    endtask

    task automatic t_timeout();
        int c0 = irq_cnt;
        fsync = 1'b0;
        bclk = 1'b0;
        repeat ((1 << TO_LOG2) + 100) @(negedge clk);
        expect_sts("R9 stopped", 31, 15, 1, 1);
        chk("R9 irq", irq_cnt - c0, 1);
    endtask

    task automatic t_unknown_rate();
        run_frames(60000.0, 64, 4);
        expect_sts("R2 60k unknown", 31, 4, 1, 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_basic();
        t_family2();
        t_tolerance();
        t_window_edge();
        t_reserved();
        t_odd_ratio();
        t_recover();
        t_agree();
        t_det_off();
        t_cfg_off();
        t_timeout();
        t_unknown_rate();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule